// File: doc/BRIEF.md
# 8-bit Timer with Compare Output

An 8-bit up-counter with one compare channel that drives a waveform pin. The counter advances on every clock. In free-running mode it rolls over from all ones to zero and raises a sticky overflow flag. In clear-on-compare mode the compare value sets the counting period: the counter returns to zero after it reaches that value. Every compare match raises a sticky compare flag. The match can also set, clear or toggle an internal output bit, or leave it alone.

Software reaches the block through one write port. A 2-bit select picks the counter, the compare value, the control fields or a force strobe. A force applies the configured output action at once, without a real match. The output bit reaches the pin only while a direction-enable input is high, so the bit can be preset while the pin is still off. Each flag is cleared by its own acknowledge input.

There are two state machines. The match gate has the states ST_ARMED and ST_BLOCKED. It moves from ST_ARMED to ST_BLOCKED on a counter load (transition "load"). It returns to ST_ARMED on the first cycle without a load (transition "release"). The output machine has the states WV_LOW and WV_HIGH. It moves to WV_HIGH on a set or toggle event ("rise") and to WV_LOW on a clear or toggle event ("fall"). An event is a compare match or a force.

Top module: `tc8_cmp_timer`

## Requirements
- R1: After reset the following all read zero: the counter, both flags, the output bit, the pin, the mode, the output setting and the compare value.
- R2: In mode 0, and in every mode value other than 2, the counter counts up by one each clock and rolls from 0xFF to 0x00. The overflow flag is set at the same edge at which the counter becomes zero from 0xFF.
- R3: Each flag stays set until its acknowledge input is high at a clock edge. A set event at the same edge as an acknowledge leaves the flag set.
- R4: In mode 2, when the counter equals the compare value, the next counter value is zero.
- R5: A compare match (counter equal to compare value, match gate armed) sets the compare flag in every mode.
- R6: The output setting acts on the output bit at a match: 0 = no action, 1 = toggle, 2 = clear, 3 = set. A setting written at the same edge as a match first acts at the following match.
- R7: A force strobe (select 3) applies the current output setting at that edge. It does not set the compare flag and does not clear the counter. A force that coincides with a match applies the action once.
- R8: A counter write (select 0) loads the data at that edge and takes priority over counting and clearing. No compare match happens at that edge or at the following edge.
- R9: The pin equals the output bit while pin_dir_en is 1 and is 0 otherwise. A force while the pin is disabled presets the bit.
- R10: Select codes are 0 = counter, 1 = compare value, 2 = control, 3 = force. For a control write, wr_data[2:0] is the mode and wr_data[5:4] is the output setting. Any write takes effect at the clock edge at which wr_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target select |
| wr_data | input | W (8) | Write data |
| ovf_ack | input | 1 | Clears the overflow flag |
| cmp_ack | input | 1 | Clears the compare flag |
| pin_dir_en | input | 1 | Drives the output bit onto the pin when high |
| count_o | output | W (8) | Current counter value |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| cmp_flag_o | output | 1 | Sticky compare flag |
| wave_pin_o | output | 1 | Gated waveform pin |

## Verification
The assertions assume that every input is stable at each rising edge and that reset is asserted before the first edge. They treat wr_en, ovf_ack and cmp_ack as plain level inputs that are sampled once per edge. The stimulus changes every input only on falling edges. It issues each write as a strobe that lasts one cycle, and it drives the acknowledges in fixed periodic patterns. These patterns sometimes land on a set event and so exercise the set-over-acknowledge priority.

// File: rtl/tc8_pkg.sv
package tc8_pkg;

    typedef enum logic [1:0] {
        SEL_COUNT = 2'd0,
        SEL_CMPV  = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_FORCE = 2'd3
    } wsel_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_TOGGLE = 2'd1,
        ACT_CLEAR  = 2'd2,
        ACT_SET    = 2'd3
    } cmp_act_e;

    typedef enum logic {
        ST_ARMED   = 1'b0,
        ST_BLOCKED = 1'b1
    } gate_state_e;

    typedef enum logic {
        WV_LOW  = 1'b0,
        WV_HIGH = 1'b1
    } wave_state_e;

    localparam int unsigned MODE_W   = 3;
    localparam logic [MODE_W-1:0] MODE_CLR_ON_CMP = 3'd2;

endpackage

// File: rtl/tc8_counter.sv
module tc8_counter
    import tc8_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_en,
    input  logic [W-1:0] ld_val,
    input  logic         ctc_en,
    input  logic [W-1:0] cmp_val,
    output logic [W-1:0] cnt_o,
    output logic         match_o,
    output logic         ovf_set_o
);
    localparam logic [W-1:0] CNT_MAX  = {W{1'b1}};
    localparam logic [W-1:0] CNT_ZERO = {W{1'b0}};

    gate_state_e state_q, state_d;
    logic [W-1:0] cnt_q;

    // State register of the match gate
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    // Next state and match output
    always_comb begin
        state_d = state_q;
        match_o = 1'b0;
        unique case (state_q)
            ST_ARMED: begin
                match_o = (cnt_q == cmp_val) && !ld_en;
                if (ld_en) state_d = ST_BLOCKED;
            end
            ST_BLOCKED: begin
                match_o = 1'b0;
                if (!ld_en) state_d = ST_ARMED;
            end
            default: state_d = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= CNT_ZERO;
        else if (ld_en)            cnt_q <= ld_val;
        else if (ctc_en && match_o) cnt_q <= CNT_ZERO;
        else                       cnt_q <= cnt_q + 1'b1;
    end

    assign ovf_set_o = !ld_en && (cnt_q == CNT_MAX);
    assign cnt_o     = cnt_q;

    // R2: the counter rolls from all ones to zero unless a load intervenes
    a_r2_rollover: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !ld_en) |=> (cnt_q == CNT_ZERO));

    // R4: clear-on-compare returns the counter to zero
    a_r4_ctc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ctc_en && match_o) |=> (cnt_q == CNT_ZERO));

    // R8: no match on the edge that follows a load
    a_r8_gate_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> !match_o);

endmodule

// File: rtl/tc8_wave.sv
module tc8_wave
    import tc8_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  cmp_act_e act,
    input  logic     match,
    input  logic     force_stb,
    output logic     wave_o
);
    wave_state_e state_q, state_d;
    logic fire;

    assign fire = match || force_stb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WV_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WV_LOW: begin
                if (fire && (act == ACT_TOGGLE || act == ACT_SET)) state_d = WV_HIGH;
            end
            WV_HIGH: begin
                if (fire && (act == ACT_TOGGLE || act == ACT_CLEAR)) state_d = WV_LOW;
            end
            default: state_d = WV_LOW;
        endcase
    end

    assign wave_o = (state_q == WV_HIGH);

    // R6: a toggle event inverts the bit
    a_r6_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && act == ACT_TOGGLE) |=> (wave_o != $past(wave_o)));

    // R6: without an event or with no action the bit holds
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire || act == ACT_NONE) |=> (wave_o == $past(wave_o)));

endmodule

// File: rtl/tc8_flag.sv
module tc8_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic ack_i,
    output logic flag_o
);
    logic q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= 1'b0;
        else if (set_i) q <= 1'b1;
        else if (ack_i) q <= 1'b0;
    end

    assign flag_o = q;

    // R3: the flag persists until acknowledged
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !ack_i) |=> q);

    // R3: a set beats a coincident acknowledge
    a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q);

endmodule

// File: rtl/tc8_cmp_timer.sv
module tc8_cmp_timer
    import tc8_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         ovf_ack,
    input  logic         cmp_ack,
    input  logic         pin_dir_en,
    output logic [W-1:0] count_o,
    output logic         ovf_flag_o,
    output logic         cmp_flag_o,
    output logic         wave_pin_o
);
    localparam int unsigned ACT_LSB = 4;

    logic [W-1:0]      cmp_val_q;
    logic [MODE_W-1:0] mode_q;
    cmp_act_e          act_q;
    logic              ld_en, cmpv_wr, ctrl_wr, force_stb;
    logic              ctc_en, match, ovf_set, wave_bit;

    assign ld_en     = wr_en && (wsel_e'(wr_sel) == SEL_COUNT);
    assign cmpv_wr   = wr_en && (wsel_e'(wr_sel) == SEL_CMPV);
    assign ctrl_wr   = wr_en && (wsel_e'(wr_sel) == SEL_CTRL);
    assign force_stb = wr_en && (wsel_e'(wr_sel) == SEL_FORCE);

    // Reserved mode values fall back to free-running counting
    assign ctc_en = (mode_q == MODE_CLR_ON_CMP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_val_q <= '0;
            mode_q    <= '0;
            act_q     <= ACT_NONE;
        end else begin
            if (cmpv_wr) cmp_val_q <= wr_data;
            if (ctrl_wr) begin
                mode_q <= wr_data[MODE_W-1:0];
                act_q  <= cmp_act_e'(wr_data[ACT_LSB+1:ACT_LSB]);
            end
        end
    end

    tc8_counter #(.W(W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_en     (ld_en),
        .ld_val    (wr_data),
        .ctc_en    (ctc_en),
        .cmp_val   (cmp_val_q),
        .cnt_o     (count_o),
        .match_o   (match),
        .ovf_set_o (ovf_set)
    );

    tc8_wave u_wave (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act_q),
        .match     (match),
        .force_stb (force_stb),
        .wave_o    (wave_bit)
    );

    tc8_flag u_ovf_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ovf_set),
        .ack_i  (ovf_ack),
        .flag_o (ovf_flag_o)
    );

    tc8_flag u_cmp_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (match),
        .ack_i  (cmp_ack),
        .flag_o (cmp_flag_o)
    );

    assign wave_pin_o = pin_dir_en && wave_bit;

    // R7: a force alone never raises the compare flag
    a_r7_force_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (force_stb && !match && !cmp_flag_o) |=> !cmp_flag_o);

    // R5: a match is always followed by a set compare flag
    a_r5_match_flag: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> cmp_flag_o);

endmodule

// File: tb/tc8_cmp_timer_tb.sv
module tc8_cmp_timer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       ovf_ack = 1'b0;
    logic       cmp_ack = 1'b0;
    logic       pin_dir_en = 1'b0;
    logic [7:0] count_o;
    logic       ovf_flag_o, cmp_flag_o, wave_pin_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    // reference model state
    int m_cnt = 0, m_ocr = 0, m_mode = 0, m_act = 0;
    int m_wave = 0, m_ovf = 0, m_cmp = 0, m_blk = 0;

    tc8_cmp_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ovf_ack(ovf_ack), .cmp_ack(cmp_ack),
        .pin_dir_en(pin_dir_en), .count_o(count_o),
        .ovf_flag_o(ovf_flag_o), .cmp_flag_o(cmp_flag_o), .wave_pin_o(wave_pin_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Reference model, stepped on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_ocr = 0; m_mode = 0; m_act = 0;
            m_wave = 0; m_ovf = 0; m_cmp = 0; m_blk = 0;
        end else begin
            bit cw, frc, hit, ovfs;
            int nxt;
            cw   = wr_en && wr_sel == 2'd0;
            frc  = wr_en && wr_sel == 2'd3;
            hit  = (m_cnt == m_ocr) && !m_blk && !cw;
            ovfs = !cw && (m_cnt == 255);
            if (cw) nxt = int'(wr_data);
            else if (m_mode == 2 && hit) nxt = 0;
            else nxt = (m_cnt + 1) % 256;
            if (hit || frc) begin
                case (m_act)
                    1: m_wave = 1 - m_wave;
                    2: m_wave = 0;
                    3: m_wave = 1;
                    default: ;
                endcase
            end
            if (hit) m_cmp = 1; else if (cmp_ack) m_cmp = 0;
            if (ovfs) m_ovf = 1; else if (ovf_ack) m_ovf = 0;
            m_blk = cw ? 1 : 0;
            m_cnt = nxt;
            if (wr_en && wr_sel == 2'd1) m_ocr = int'(wr_data);
            if (wr_en && wr_sel == 2'd2) begin
                m_mode = int'(wr_data[2:0]);
                m_act  = int'(wr_data[5:4]);
            end
        end
    end

    // Compare after each edge, away from it
    always @(posedge clk) begin
        #2;
        cyc++;
        if (rst_n) begin
            check("R2 R4 R8 count", int'(count_o), m_cnt);
            check("R2 R3 overflow flag", int'(ovf_flag_o), m_ovf);
            check("R3 R5 R8 compare flag", int'(cmp_flag_o), m_cmp);
            check("R6 R7 R9 pin", int'(wave_pin_o), pin_dir_en ? m_wave : 0);
        end
    end

    // Periodic acknowledges
    always @(negedge clk) begin
        ovf_ack <= (cyc % 37) == 0;
        cmp_ack <= (cyc % 23) == 5;
    end

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        #1;
        check("R1 reset count", int'(count_o), 0);
        check("R1 reset ovf flag", int'(ovf_flag_o), 0);
        check("R1 reset cmp flag", int'(cmp_flag_o), 0);
        check("R1 reset pin", int'(wave_pin_o), 0);
        pin_dir_en = 1'b1;

        // R10: control byte = {setting[5:4], mode[2:0]}
        wr(2'd2, 8'h10);          // normal mode, toggle
        wr(2'd1, 8'h40);
        idle(600);
        wr(2'd0, 8'hFD);          // R2 rollover soon after load
        idle(10);
        wr(2'd2, 8'h25);          // reserved mode 5, clear
        idle(300);
        wr(2'd2, 8'h02);          // R4 clear-on-compare, no action
        wr(2'd1, 8'd12);
        idle(60);
        wr(2'd2, 8'h32); idle(40); // R6 set
        wr(2'd2, 8'h22); idle(40); // R6 clear
        wr(2'd2, 8'h12); idle(60); // R6 toggle
        wr(2'd0, 8'd12); idle(20); // R8 load equal to compare value
        wr(2'd0, 8'd11); idle(20); // R8 load one below
        wr(2'd1, 8'hFF); idle(600); // R2 R4 compare at all ones
        wr(2'd1, 8'd50);
        for (int i = 0; i < 40; i++) begin // R7 forces, some on matches
            wr(2'd3, 8'h00);
            idle(i % 3);
        end

        // R9 preset while the pin is disabled
        wr(2'd2, 8'h20); wr(2'd3, 8'h00);
        pin_dir_en = 1'b0;
        wr(2'd2, 8'h30);            // normal mode, set
        wr(2'd3, 8'h00);
        #1;
        check("R9 pin gated", int'(wave_pin_o), 0);
        pin_dir_en = 1'b1;
        #1;
        check("R9 preset visible", int'(wave_pin_o), 1);
        idle(300);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule